// File: doc/BRIEF.md
# Multi-Mode Up/Down Counter Channel with Dual Capture

This block is one 32-bit counting channel with two capture registers, named A and B, and a small register interface. In event mode the count follows two external inputs, a step/select pair. These inputs are read either as a clock with a direction level or as a 4x quadrature encoder. In pulse-width mode the count advances on an internal reference tick instead, taken at full rate or through a divide-by-4 prescaler. A third external input, the control line, clears or captures the count in event mode. In pulse-width mode it stamps the count into capture A on its rising edge and into capture B on its falling edge, so the high time of that line can be measured.

Software sets the mode through a control register. It issues single-cycle command strobes to clear the count, capture into either register, and clear the sticky encoder error flag. It reads the count, both captures and the control and status word back through a combinational read port. The three external lines are asynchronous and each passes through a two-flop synchronizer. Edges are then found against the system clock.

Top module: `mmcnt_channel`

## Requirements
- R1: After reset, the control word, error flag, count, capture A and capture B all read as zero.
- R2: In clock/direction mode (CTRL[2:1]=0), each rising edge of `ext_a` adds one to the count when `ext_b` is 1 and subtracts one when `ext_b` is 0. Falling edges of `ext_a` and any change of `ext_b` leave the count unchanged.
- R3: In quadrature mode (CTRL[2:1]=1), the (a,b) cycle 00→10→11→01→00 counts up by one per transition, and the reverse cycle counts down by one per transition.
- R4: In quadrature mode, a transition in which a and b change together does not change the count. It sets a sticky error flag, read at CTRL bit 8, which stays set until a command write with bit 3 set.
- R5: In pulse-width mode (CTRL[2:1]=2), the count rises by one per `ref_tick` pulse when CTRL bit 4 is 0. When bit 4 is 1 it rises by one per four pulses, and the prescaler restarts whenever the count is cleared.
- R6: In pulse-width mode, a rising edge of `ext_c` copies the count into capture A and a falling edge copies it into capture B.
- R7: In either event mode, a rising edge of `ext_c` clears the count when CTRL bit 3 is 0 and copies it into capture A when CTRL bit 3 is 1. A falling edge has no effect.
- R8: A write to the command register (address 1) clears the count with bit 0, captures into A with bit 1 and captures into B with bit 2, in any mode. Each capture register keeps its value until its next capture.
- R9: CTRL bit 0 enables counting. While it is 0 the count does not move, but clears and captures still act.
- R10: The count wraps modulo 2^32: one step down from 0 gives 0xFFFFFFFF and one step up from there gives 0.
- R11: When a clear and a count step fall in the same cycle, the count becomes 0. When a capture and a count step fall in the same cycle, the capture receives the count from before that step.
- R12: Address 0 holds the control word: bit 0 enable, bits 2:1 mode, bit 3 event-mode line function, bit 4 prescaler select. It reads back as written, with the error flag at bit 8. Addresses 2, 3 and 4 read the count, capture A and capture B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_a | input | 1 | Asynchronous clock / encoder phase A input |
| ext_b | input | 1 | Asynchronous direction / encoder phase B input |
| ext_c | input | 1 | Asynchronous clear / capture control line |
| ref_tick | input | 1 | One-cycle reference pulse at full reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |

## Verification
The hardest situations to reach from the ports are the same-cycle races of R11, where a software clear or capture meets a counting step on one clock edge. The bench reaches them in pulse-width mode by using the unsynchronized reference tick. It raises `ref_tick` on the same falling edge that presents the command write and drops both one cycle later, so exactly one step and one command share a single rising edge. In that case a wrong priority leaves the count at one, and a late capture reads one more than the value before the step. The quadrature error path is driven by presenting both encoder lines changed on the same edge, so both cross the synchronizer together.

// File: rtl/mmcnt_pkg.sv
package mmcnt_pkg;

    localparam int CNT_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMD   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CAPA  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CAPB  = 3'd4;

    localparam int ERR_BIT = 8;

    typedef enum logic [1:0] {
        MODE_CLKDIR = 2'd0,
        MODE_QUAD   = 2'd1,
        MODE_PULSE  = 2'd2
    } mode_e;

    // bit 4 prescaler, bit 3 line function, bits 2:1 mode, bit 0 enable
    typedef struct packed {
        logic  ref_div4;
        logic  line_cap;
        mode_e mode;
        logic  enable;
    } ctrl_t;

    typedef struct packed {
        logic err_clr;
        logic cap_b;
        logic cap_a;
        logic clr;
    } cmd_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic err;
    } step_t;

    function automatic mode_e mode_of(input logic [1:0] raw);
        case (raw)
            2'd1:    return MODE_QUAD;
            2'd2:    return MODE_PULSE;
            default: return MODE_CLKDIR;
        endcase
    endfunction

    // position of an (a,b) pair on the forward encoder cycle 00,10,11,01
    function automatic logic [1:0] quad_pos(input logic [1:0] ab);
        case (ab)
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic step_t quad_step(input logic [1:0] ab_old,
                                        input logic [1:0] ab_new);
        logic [1:0] d;
        step_t      s;
        d = quad_pos(ab_new) - quad_pos(ab_old);
        s = '0;
        case (d)
            2'd1:    s.up  = 1'b1;
            2'd3:    s.dn  = 1'b1;
            2'd2:    s.err = 1'b1;
            default: s     = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mmcnt_sync.sv
module mmcnt_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/mmcnt_decode.sv
module mmcnt_decode
    import mmcnt_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  a_s,
    input  logic  b_s,
    input  logic  c_s,
    input  logic  ref_tick,
    input  ctrl_t ctrl,
    input  logic  div_rst,
    output step_t step,
    output logic  line_clr,
    output logic  line_cap_a,
    output logic  line_cap_b
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    logic             a_p, b_p, c_p;
    logic [DIV_W-1:0] div_cnt;
    logic             a_rise, c_rise, c_fall, tick_go;
    logic             pulse_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
            c_p <= 1'b0;
        end else begin
            a_p <= a_s;
            b_p <= b_s;
            c_p <= c_s;
        end
    end

    assign pulse_mode = (ctrl.mode == MODE_PULSE);

    always_ff @(posedge clk) begin
        if (rst || div_rst) begin
            div_cnt <= '0;
        end else if (ref_tick && pulse_mode && ctrl.ref_div4) begin
            div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
        end
    end

    assign tick_go = ref_tick && (!ctrl.ref_div4 || div_cnt == DIV_LAST);
    assign a_rise  = a_s & ~a_p;
    assign c_rise  = c_s & ~c_p;
    assign c_fall  = ~c_s & c_p;

    always_comb begin
        step = '0;
        case (ctrl.mode)
            MODE_CLKDIR: begin
                step.up = a_rise & b_s;
                step.dn = a_rise & ~b_s;
            end
            MODE_QUAD:  step = quad_step({a_p, b_p}, {a_s, b_s});
            MODE_PULSE: step.up = tick_go;
            default:    step = '0;
        endcase
    end

    always_comb begin
        line_clr   = 1'b0;
        line_cap_a = 1'b0;
        line_cap_b = 1'b0;
        if (pulse_mode) begin
            line_cap_a = c_rise;
            line_cap_b = c_fall;
        end else begin
            line_clr   = c_rise & ~ctrl.line_cap;
            line_cap_a = c_rise &  ctrl.line_cap;
        end
    end

    AST_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step.up, step.dn, step.err}))
        else $error("step outputs not exclusive"); // R4

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && ctrl.ref_div4 && step.up) |=> (!$stable(ctrl) || !step.up))
        else $error("prescaled tick on consecutive cycles"); // R5

    AST_EDGE_ONE: assert property (@(posedge clk) disable iff (rst)
        !(line_cap_a && line_cap_b))
        else $error("both captures from one line edge"); // R6
endmodule

// File: rtl/mmcnt_regs.sv
module mmcnt_regs
    import mmcnt_pkg::*;
#(
    parameter int DATA_W = CNT_W,
    parameter int AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic              err_set,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] cap_a_val,
    input  logic [DATA_W-1:0] cap_b_val,
    output ctrl_t             ctrl,
    output cmd_t              cmd,
    output logic              err_flag,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int CMD_W  = $bits(cmd_t);

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl.enable   <= wr_data[0];
            ctrl.mode     <= mode_of(wr_data[2:1]);
            ctrl.line_cap <= wr_data[3];
            ctrl.ref_div4 <= wr_data[4];
        end
    end

    assign cmd = (wr_en && wr_addr == ADDR_CMD) ? cmd_t'(wr_data[CMD_W-1:0]) : '0;

    // a new error outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)              err_flag <= 1'b0;
        else if (err_set)     err_flag <= 1'b1;
        else if (cmd.err_clr) err_flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_W-1:0] = ctrl;
                rd_data[ERR_BIT]    = err_flag;
            end
            ADDR_COUNT: rd_data = count;
            ADDR_CAPA:  rd_data = cap_a_val;
            ADDR_CAPB:  rd_data = cap_b_val;
            default:    rd_data = '0;
        endcase
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !cmd.err_clr) |=> err_flag)
        else $error("error flag dropped without clear"); // R4

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        err_set |=> err_flag)
        else $error("error flag not set"); // R4
endmodule

// File: rtl/mmcnt_core.sv
module mmcnt_core #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          up,
    input  logic          dn,
    input  logic          clr,
    input  logic          cap_a,
    input  logic          cap_b,
    output logic [CW-1:0] count,
    output logic [CW-1:0] cap_a_val,
    output logic [CW-1:0] cap_b_val
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || clr)         count <= '0;
        else if (enable && up)  count <= count + ONE;
        else if (enable && dn)  count <= count - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a_val <= '0;
            cap_b_val <= '0;
        end else begin
            if (cap_a) cap_a_val <= count;
            if (cap_b) cap_b_val <= count;
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0))
        else $error("clear lost to a count step"); // R11

    AST_CAP_PRE: assert property (@(posedge clk) disable iff (rst)
        cap_a |=> (cap_a_val == $past(count)))
        else $error("capture A took a post-step value"); // R11

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!enable && !clr) |=> $stable(count))
        else $error("count moved while disabled"); // R9

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (count == $past(count) || count == $past(count) + ONE
                  || count == $past(count) - ONE))
        else $error("count jumped by more than one"); // R10

    AST_CAPB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_b |=> $stable(cap_b_val))
        else $error("capture B changed without capture"); // R8
endmodule

// File: rtl/mmcnt_channel.sv
module mmcnt_channel
    import mmcnt_pkg::*;
#(
    parameter int CW      = CNT_W,
    parameter int AW      = ADDR_W,
    parameter int SYNC_ST = 2,
    parameter int REF_DIV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_a,
    input  logic          ext_b,
    input  logic          ext_c,
    input  logic          ref_tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data
);
    logic [2:0]    lines_s;
    ctrl_t         ctrl;
    cmd_t          cmd;
    step_t         step;
    logic          line_clr, line_cap_a, line_cap_b;
    logic          clr_any, cap_a_any, cap_b_any;
    logic          err_flag;
    logic [CW-1:0] count, cap_a_val, cap_b_val;

    mmcnt_sync #(.W(3), .STAGES(SYNC_ST)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({ext_a, ext_b, ext_c}),
        .q_sync  (lines_s)
    );

    mmcnt_decode #(.DIV(REF_DIV)) i_decode (
        .clk        (clk),
        .rst        (rst),
        .a_s        (lines_s[2]),
        .b_s        (lines_s[1]),
        .c_s        (lines_s[0]),
        .ref_tick   (ref_tick),
        .ctrl       (ctrl),
        .div_rst    (clr_any),
        .step       (step),
        .line_clr   (line_clr),
        .line_cap_a (line_cap_a),
        .line_cap_b (line_cap_b)
    );

    assign clr_any   = cmd.clr   | line_clr;
    assign cap_a_any = cmd.cap_a | line_cap_a;
    assign cap_b_any = cmd.cap_b | line_cap_b;

    mmcnt_core #(.CW(CW)) i_core (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.enable),
        .up        (step.up),
        .dn        (step.dn),
        .clr       (clr_any),
        .cap_a     (cap_a_any),
        .cap_b     (cap_b_any),
        .count     (count),
        .cap_a_val (cap_a_val),
        .cap_b_val (cap_b_val)
    );

    mmcnt_regs #(.DATA_W(CW), .AW(AW)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .err_set   (step.err),
        .count     (count),
        .cap_a_val (cap_a_val),
        .cap_b_val (cap_b_val),
        .ctrl      (ctrl),
        .cmd       (cmd),
        .err_flag  (err_flag),
        .rd_data   (rd_data)
    );

    AST_ERR_QUAD_ONLY: assert property (@(posedge clk) disable iff (rst)
        step.err |-> (ctrl.mode == MODE_QUAD))
        else $error("encoder error outside quadrature mode"); // R4

    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (count == '0 && !err_flag))
        else $error("state not cleared by reset"); // R1
endmodule

// File: tb/test_mmcnt_channel.sv
module test_mmcnt_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_a = 1'b0, ext_b = 1'b0, ext_c = 1'b0, ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    mmcnt_channel i_mmcnt_channel (
        .clk(clk), .rst(rst), .ext_a(ext_a), .ext_b(ext_b), .ext_c(ext_c),
        .ref_tick(ref_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ctl(bit en, logic [1:0] mode, bit line_cap, bit div4);
        return {27'd0, div4, line_cap, mode, en};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic lines(bit a, bit b, bit c);
        @(negedge clk);
        ext_a = a; ext_b = b; ext_c = c;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_a(int n);
        for (int i = 0; i < n; i++) begin
            lines(1'b1, ext_b, ext_c);
            lines(1'b0, ext_b, ext_c);
        end
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic expect_reg(string tag, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 3'd0, 32'd0);
        expect_reg("R1 count", 3'd2, 32'd0);
        expect_reg("R1 capA", 3'd3, 32'd0);
        expect_reg("R1 capB", 3'd4, 32'd0);
        wr(3'd0, ctl(1, 2'd2, 1, 1));
        expect_reg("R12 ctrl readback", 3'd0, 32'h1d);
        wr(3'd0, ctl(1, 2'd0, 0, 0));
        expect_reg("R12 ctrl readback2", 3'd0, 32'h01);
    endtask

    task automatic t_clkdir();
        lines(1'b0, 1'b1, 1'b0);
        pulse_a(3);
        expect_reg("R2 up count", 3'd2, 32'd3);
        lines(1'b0, 1'b0, 1'b0);
        pulse_a(2);
        expect_reg("R2 down count", 3'd2, 32'd1);
        lines(1'b0, 1'b1, 1'b0);
        lines(1'b1, 1'b1, 1'b0);
        expect_reg("R2 rising only", 3'd2, 32'd2);
        lines(1'b0, 1'b1, 1'b0);
        lines(1'b0, 1'b0, 1'b0);
        expect_reg("R2 falling and dir no effect", 3'd2, 32'd2);
    endtask

    task automatic t_quad();
        wr(3'd1, 32'h1);
        wr(3'd0, ctl(1, 2'd1, 0, 0));
        lines(1, 0, 0); lines(1, 1, 0); lines(0, 1, 0); lines(0, 0, 0); lines(1, 0, 0);
        expect_reg("R3 forward", 3'd2, 32'd5);
        lines(0, 0, 0); lines(0, 1, 0); lines(1, 1, 0);
        expect_reg("R3 reverse", 3'd2, 32'd2);
    endtask

    task automatic t_quad_err();
        lines(0, 0, 0);
        expect_reg("R4 illegal no count", 3'd2, 32'd2);
        expect_reg("R4 error set", 3'd0, 32'h103);
        lines(1, 0, 0);
        expect_reg("R4 count after error", 3'd2, 32'd3);
        expect_reg("R4 error sticky", 3'd0, 32'h103);
        wr(3'd1, 32'h8);
        expect_reg("R4 error cleared", 3'd0, 32'h003);
        lines(0, 0, 0);
    endtask

    task automatic t_wrap();
        wr(3'd0, ctl(1, 2'd0, 0, 0));
        wr(3'd1, 32'h1);
        lines(0, 0, 0);
        pulse_a(1);
        expect_reg("R10 wrap down", 3'd2, 32'hffff_ffff);
        lines(0, 1, 0);
        pulse_a(1);
        expect_reg("R10 wrap up", 3'd2, 32'd0);
    endtask

    task automatic t_enable();
        pulse_a(3);
        wr(3'd0, ctl(0, 2'd0, 0, 0));
        pulse_a(2);
        expect_reg("R9 disabled hold", 3'd2, 32'd3);
        wr(3'd1, 32'h4);
        expect_reg("R9 capture while disabled", 3'd4, 32'd3);
        wr(3'd0, ctl(1, 2'd0, 0, 0));
    endtask

    task automatic t_sw_cmds();
        wr(3'd1, 32'h2);
        expect_reg("R8 sw capture A", 3'd3, 32'd3);
        wr(3'd1, 32'h1);
        expect_reg("R8 sw clear", 3'd2, 32'd0);
        expect_reg("R8 capA holds", 3'd3, 32'd3);
        expect_reg("R8 capB holds", 3'd4, 32'd3);
    endtask

    task automatic t_line_event();
        pulse_a(2);
        lines(0, 1, 1);
        expect_reg("R7 line clears", 3'd2, 32'd0);
        lines(0, 1, 0);
        pulse_a(4);
        wr(3'd0, ctl(1, 2'd0, 1, 0));
        lines(0, 1, 1);
        expect_reg("R7 line captures A", 3'd3, 32'd4);
        expect_reg("R7 count kept", 3'd2, 32'd4);
        lines(0, 1, 0);
        expect_reg("R7 falling no effect", 3'd2, 32'd4);
    endtask

    task automatic t_pulse_rate();
        wr(3'd0, ctl(1, 2'd2, 0, 0));
        wr(3'd1, 32'h1);
        ticks(10);
        expect_reg("R5 full rate", 3'd2, 32'd10);
        wr(3'd0, ctl(1, 2'd2, 0, 1));
        wr(3'd1, 32'h1);
        ticks(12);
        expect_reg("R5 divided rate", 3'd2, 32'd3);
    endtask

    task automatic t_pulse_width();
        wr(3'd0, ctl(1, 2'd2, 0, 0));
        wr(3'd1, 32'h1);
        ticks(10);
        lines(0, 1, 1);
        expect_reg("R6 rising to A", 3'd3, 32'd10);
        ticks(6);
        lines(0, 1, 0);
        expect_reg("R6 falling to B", 3'd4, 32'd16);
    endtask

    task automatic t_race();
        logic [31:0] c, a;
        ticks(5);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h1; ref_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ref_tick = 1'b0;
        expect_reg("R11 clear beats step", 3'd2, 32'd0);
        ticks(5);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h2; ref_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ref_tick = 1'b0;
        rd(3'd3, a);
        rd(3'd2, c);
        chk("R11 capture pre-step", a, 32'd5);
        chk("R11 count after step", c, 32'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clkdir();
        t_quad();
        t_quad_err();
        t_wrap();
        t_enable();
        t_sw_cmds();
        t_line_event();
        t_pulse_rate();
        t_pulse_width();
        t_race();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule